// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a segment selector and a 16-bit offset into a 24-bit physical address. The selector does not hold a base address. It names one descriptor in one of two descriptor tables: a global table shared by all tasks and a local table for one task. The descriptor gives the segment's base, its largest legal offset, the privilege ring it belongs to, and a present flag. When every check passes, the block adds the offset to the base. When a check fails, it reports a fault with a cause code and gives no address.

The descriptor entries are held locally in two register tables. Each table is filled through a write port, and the number of entries per table is set by a parameter. Requests arrive with a valid strobe. Each request gets exactly one response, and a new request can be accepted on every cycle. The response is registered by default, and a parameter can remove that register.

Top module: `segdesc_xlate`

## Requirements
- R1: After reset, rsp_valid is 0 and every descriptor in both tables is marked not present, so any request faults with the absent cause.
- R2: With the default registered output, rsp_valid is 1 exactly one cycle after each cycle in which req_valid is 1, and 0 otherwise. Requests may arrive on consecutive cycles.
- R3: The selector fields are: bits [15:3] the descriptor index, bit [2] the table (0 global, 1 local), bits [1:0] the requested privilege number.
- R4: A write with dt_we=1 stores one descriptor into the table picked by dt_tbl (0 global, 1 local) at dt_idx. A request in any later cycle sees the stored value, and the other table is left unchanged.
- R5: On success, rsp_addr equals (descriptor base + zero-extended offset) modulo 2^24.
- R6: The limit is the largest legal offset and is inclusive. An offset greater than the limit faults with cause 2'b10.
- R7: A requested privilege number that is numerically greater than the descriptor ring faults with cause 2'b11.
- R8: A descriptor that is not present, or a selector index at or beyond the table depth (2^IDX_W), faults with cause 2'b01.
- R9: When several checks fail together, the reported cause is picked in this order: absent first, then privilege, then limit.
- R10: On a fault, rsp_fault is 1 and rsp_addr is 0. On success, rsp_fault is 0 and rsp_cause is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dt_we | input | 1 | Descriptor write strobe |
| dt_tbl | input | 1 | Target table for the write (0 global, 1 local) |
| dt_idx | input | IDX_W | Entry index for the write |
| dt_base | input | 24 | Segment base address to store |
| dt_limit | input | 16 | Largest legal offset to store |
| dt_ring | input | 2 | Segment privilege ring to store |
| dt_present | input | 1 | Present flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 16 | Selector (index, table bit, requested privilege) |
| req_off | input | 16 | Offset within the segment |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | 24 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 2 | 00 none, 01 absent, 10 limit, 11 privilege |

## Verification
A corrupted table entry appears only when that entry is selected. It shows up in the first response after the request as a wrong address or a wrong cause. For that reason the directed tests write distinct bases into the same index of both tables and read each one back. A wrong comparison boundary or a wrong priority choice appears in the first response to a request placed exactly on that boundary or that overlap, so those exact points are tested. A slip in the response pipeline shows up within one cycle, as a missing or extra strobe during back-to-back requests.

// File: rtl/segx_pkg.sv
package segx_pkg;
   localparam int SEL_W     = 16;
   localparam int SEL_IDX_W = 13;
   localparam int BASE_W    = 24;
   localparam int LIM_W     = 16;
   localparam int OFF_W     = 16;
   localparam int RING_W    = 2;

   typedef struct packed {
      logic              present;
      logic [RING_W-1:0] ring;
      logic [LIM_W-1:0]  limit;
      logic [BASE_W-1:0] base;
   } seg_desc_t;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'b00,
      CAUSE_ABSENT = 2'b01,
      CAUSE_LIMIT  = 2'b10,
      CAUSE_PRIV   = 2'b11
   } fault_cause_t;
endpackage

// File: rtl/segx_table.sv
module segx_table
   import segx_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  seg_desc_t        wr_desc,
   input  logic [IDX_W-1:0] rd_idx,
   output seg_desc_t        rd_desc
);
   localparam int DEPTH = 2 ** IDX_W;

   seg_desc_t ents [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
      end else if (wr_en) begin
         ents[wr_idx] <= wr_desc;
      end
   end

   assign rd_desc = ents[rd_idx];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ents[$past(wr_idx)] == $past(wr_desc)); // R4
endmodule

// File: rtl/segx_check.sv
module segx_check
   import segx_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SEL_W-1:0]  sel,
   input  logic [OFF_W-1:0]  off,
   input  seg_desc_t         desc,
   output logic              fault,
   output fault_cause_t      cause,
   output logic [BASE_W-1:0] addr
);
   localparam int DEPTH = 2 ** IDX_W;

   logic [SEL_IDX_W-1:0] sel_idx;
   logic [RING_W-1:0]    sel_rpl;
   logic                 in_range;
   logic                 absent;
   logic                 priv_bad;
   logic                 lim_bad;
   logic [BASE_W-1:0]    sum;

   assign sel_idx  = sel[SEL_W-1:3];
   assign sel_rpl  = sel[RING_W-1:0];
   assign in_range = int'(sel_idx) < DEPTH;
   assign absent   = !in_range || !desc.present;
   assign priv_bad = sel_rpl > desc.ring;
   assign lim_bad  = off > desc.limit;
   assign sum      = desc.base + BASE_W'(off);

   always_comb begin
      if (absent)        cause = CAUSE_ABSENT;
      else if (priv_bad) cause = CAUSE_PRIV;
      else if (lim_bad)  cause = CAUSE_LIMIT;
      else               cause = CAUSE_NONE;
      fault = (cause != CAUSE_NONE);
      addr  = fault ? '0 : sum;
   end

   AST_LIMIT_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cause == CAUSE_NONE) |-> off <= desc.limit); // R6
   AST_PRIV_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cause == CAUSE_NONE) |-> sel_rpl <= desc.ring); // R7
   AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_range && !desc.present) |-> cause == CAUSE_ABSENT); // R9
endmodule

// File: rtl/segx_resp.sv
module segx_resp
   import segx_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_fault,
   input  fault_cause_t      in_cause,
   input  logic [BASE_W-1:0] in_addr,
   output logic              out_valid,
   output logic              out_fault,
   output fault_cause_t      out_cause,
   output logic [BASE_W-1:0] out_addr
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_cause <= CAUSE_NONE;
            out_addr  <= '0;
         end else begin
            out_valid <= in_valid;
            out_fault <= in_valid & in_fault;
            out_cause <= in_valid ? in_cause : CAUSE_NONE;
            out_addr  <= in_valid ? in_addr : '0;
         end
      end

      AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R2
      AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid); // R2
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_fault = in_valid & in_fault;
      assign out_cause = in_valid ? in_cause : CAUSE_NONE;
      assign out_addr  = in_valid ? in_addr : '0;
   end
endmodule

// File: rtl/segdesc_xlate.sv
module segdesc_xlate
   import segx_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dt_we,
   input  logic              dt_tbl,
   input  logic [IDX_W-1:0]  dt_idx,
   input  logic [23:0]       dt_base,
   input  logic [15:0]       dt_limit,
   input  logic [1:0]        dt_ring,
   input  logic              dt_present,
   input  logic              req_valid,
   input  logic [15:0]       req_sel,
   input  logic [15:0]       req_off,
   output logic              rsp_valid,
   output logic [23:0]       rsp_addr,
   output logic              rsp_fault,
   output logic [1:0]        rsp_cause
);
   localparam int NUM_TBL = 2;

   if (IDX_W < 1 || IDX_W > SEL_IDX_W) begin : g_bad_idx_w
      $error("IDX_W must lie between 1 and the selector index width");
   end

   seg_desc_t          wr_desc;
   seg_desc_t          tbl_rd [NUM_TBL];
   seg_desc_t          sel_desc;
   logic [IDX_W-1:0]   rd_idx;
   logic               chk_fault;
   fault_cause_t       chk_cause;
   fault_cause_t       out_cause;
   logic [BASE_W-1:0]  chk_addr;

   assign wr_desc = '{present: dt_present, ring: dt_ring, limit: dt_limit, base: dt_base};
   assign rd_idx  = req_sel[3 +: IDX_W];

   for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
      segx_table #(.IDX_W(IDX_W)) u_tbl (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (dt_we && (dt_tbl == 1'(t))),
         .wr_idx  (dt_idx),
         .wr_desc (wr_desc),
         .rd_idx  (rd_idx),
         .rd_desc (tbl_rd[t])
      );
   end

   assign sel_desc = tbl_rd[req_sel[2]];

   segx_check #(.IDX_W(IDX_W)) u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (req_valid),
      .sel      (req_sel),
      .off      (req_off),
      .desc     (sel_desc),
      .fault    (chk_fault),
      .cause    (chk_cause),
      .addr     (chk_addr)
   );

   segx_resp #(.OUT_REG(OUT_REG)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_fault  (chk_fault),
      .in_cause  (chk_cause),
      .in_addr   (chk_addr),
      .out_valid (rsp_valid),
      .out_fault (rsp_fault),
      .out_cause (out_cause),
      .out_addr  (rsp_addr)
   );

   assign rsp_cause = out_cause;

   AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> rsp_addr == '0); // R10
   AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00))); // R10
endmodule

// File: tb/tb_segdesc_xlate.sv
module tb_segdesc_xlate;
   localparam int IDX_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dt_we = 1'b0;
   logic              dt_tbl = 1'b0;
   logic [IDX_W-1:0]  dt_idx = '0;
   logic [23:0]       dt_base = '0;
   logic [15:0]       dt_limit = '0;
   logic [1:0]        dt_ring = '0;
   logic              dt_present = 1'b0;
   logic              req_valid = 1'b0;
   logic [15:0]       req_sel = '0;
   logic [15:0]       req_off = '0;
   logic              rsp_valid;
   logic [23:0]       rsp_addr;
   logic              rsp_fault;
   logic [1:0]        rsp_cause;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   segdesc_xlate #(.IDX_W(IDX_W), .OUT_REG(1'b1)) dut (.*);

   function automatic logic [15:0] mk_sel(input int idx, input bit tbl, input int rpl);
      return {13'(idx), tbl, 2'(rpl)};
   endfunction

   task automatic compare(input string tag, input logic v, input logic f,
                          input logic [1:0] c, input logic [23:0] a);
      n_cmp++;
      if (rsp_valid !== v || rsp_fault !== f || rsp_cause !== c || rsp_addr !== a) begin
         n_bad++;
         $display("FAIL %s: got valid=%0b fault=%0b cause=%0d addr=%h, expected valid=%0b fault=%0b cause=%0d addr=%h",
                  tag, rsp_valid, rsp_fault, rsp_cause, rsp_addr, v, f, c, a);
      end
   endtask

   task automatic wr(input bit tbl, input int idx, input logic [23:0] base,
                     input logic [15:0] lim, input int ring, input bit pres);
      @(negedge clk);
      dt_we = 1'b1; dt_tbl = tbl; dt_idx = IDX_W'(idx);
      dt_base = base; dt_limit = lim; dt_ring = 2'(ring); dt_present = pres;
      @(negedge clk);
      dt_we = 1'b0;
   endtask

   // One request; result is registered at the next posedge, sampled at the following negedge.
   task automatic xlate(input logic [15:0] sel, input logic [15:0] off);
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; req_off = off;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_ok(input string tag, input logic [23:0] a);
      compare(tag, 1'b1, 1'b0, 2'b00, a);
   endtask

   task automatic expect_fault(input string tag, input logic [1:0] c);
      compare(tag, 1'b1, 1'b1, c, 24'h0);
   endtask

   task automatic t_reset;
      compare("R1 idle after reset", 1'b0, 1'b0, 2'b00, 24'h0);
      xlate(mk_sel(0, 1'b0, 0), 16'h0000);
      expect_fault("R1 global entry absent after reset", 2'b01);
      xlate(mk_sel(5, 1'b1, 0), 16'h0000);
      expect_fault("R1 local entry absent after reset", 2'b01);
   endtask

   task automatic t_basic;
      wr(1'b0, 2, 24'h012000, 16'hFFFF, 3, 1'b1);
      wr(1'b1, 2, 24'h340000, 16'h0FFF, 3, 1'b1);
      xlate(mk_sel(2, 1'b0, 0), 16'h0345);
      expect_ok("R5 global base plus offset", 24'h012345);
      xlate(mk_sel(2, 1'b1, 0), 16'h0345);
      expect_ok("R3 table bit selects local", 24'h340345);
      xlate(mk_sel(2, 1'b0, 3), 16'h0001);
      expect_ok("R4 global entry kept after local write", 24'h012001);
   endtask

   task automatic t_limit;
      wr(1'b0, 7, 24'h100000, 16'h00FF, 3, 1'b1);
      xlate(mk_sel(7, 1'b0, 0), 16'h00FF);
      expect_ok("R6 offset equal to limit accepted", 24'h1000FF);
      xlate(mk_sel(7, 1'b0, 0), 16'h0100);
      expect_fault("R6 offset one past limit", 2'b10);
   endtask

   task automatic t_priv;
      wr(1'b1, 4, 24'h200000, 16'hFFFF, 1, 1'b1);
      xlate(mk_sel(4, 1'b1, 2), 16'h0010);
      expect_fault("R7 requested level above ring", 2'b11);
      xlate(mk_sel(4, 1'b1, 1), 16'h0010);
      expect_ok("R7 requested level equal to ring", 24'h200010);
      xlate(mk_sel(4, 1'b1, 0), 16'h0020);
      expect_ok("R7 requested level below ring", 24'h200020);
   endtask

   task automatic t_priority;
      wr(1'b0, 9, 24'h0A0000, 16'h0010, 0, 1'b0);
      xlate(mk_sel(9, 1'b0, 3), 16'h0500);
      expect_fault("R9 absent wins over privilege and limit", 2'b01);
      wr(1'b0, 9, 24'h0A0000, 16'h0010, 0, 1'b1);
      xlate(mk_sel(9, 1'b0, 3), 16'h0500);
      expect_fault("R9 privilege wins over limit", 2'b11);
      xlate(mk_sel(9, 1'b0, 0), 16'h0500);
      expect_fault("R10 limit fault address zero", 2'b10);
   endtask

   task automatic t_wrap_range;
      wr(1'b1, 15, 24'hFFFF00, 16'hFFFF, 3, 1'b1);
      xlate(mk_sel(15, 1'b1, 0), 16'h0200);
      expect_ok("R5 sum wraps modulo 2^24", 24'h000100);
      xlate(mk_sel(16, 1'b1, 0), 16'h0000);
      expect_fault("R8 index at table depth", 2'b01);
      xlate(mk_sel(8191, 1'b0, 0), 16'h0000);
      expect_fault("R8 largest selector index", 2'b01);
      wr(1'b1, 15, 24'hFFFF00, 16'hFFFF, 3, 1'b0);
      xlate(mk_sel(15, 1'b1, 0), 16'h0000);
      expect_fault("R8 entry rewritten as absent", 2'b01);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      req_valid = 1'b1; req_sel = mk_sel(2, 1'b0, 0); req_off = 16'h0010;
      @(negedge clk);
      req_sel = mk_sel(2, 1'b1, 0); req_off = 16'h0020;
      expect_ok("R2 first of back-to-back", 24'h012010);
      @(negedge clk);
      req_valid = 1'b0;
      expect_ok("R2 second of back-to-back", 24'h340020);
      @(negedge clk);
      compare("R2 no strobe without request", 1'b0, 1'b0, 2'b00, 24'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_limit;
      t_priv;
      t_priority;
      t_wrap_range;
      t_back_to_back;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule